// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block runs the complete series of debug-port operations that programs one flash word or erases flash on a target under debug control. A single start pulse captures a command, a target address, a data word, an erase-mode code and an erase pulse count. The block then works through a fixed series of steps. It halts the target CPU and writes the three flash control registers with keyed values. It then writes the data word, or for an erase a dummy word, to the target address. After that it pulls the test clock low and shifts a control word that puts the target back into read mode. It then sends a counted train of test-clock pulses, locks the flash control register again and releases the CPU.

Each step goes to a neighbour over a simple request/acknowledge pair. Memory writes go to a memory access sequencer. Halt and release requests go to the CPU control logic. Raw control words go to the data-register shifter. The test-clock pulse train is generated inside the block. The flash operation is timed only by the number of pulses. The block never polls a status flag. A single-cycle `done` marks the end of the whole series.

Top module: `flash_seq`

## Requirements
- R1: After a start accepted while idle, the first request issued is a halt request (`halt_req`), and no memory write is requested before the halt is acknowledged.
- R2: Three control writes follow the halt in this order. Address 0x0128 receives 0xA540 when `erase`=0 (program), or the `erase_mode` value unmodified when `erase`=1. Address 0x012A then receives 0xA540. Address 0x012C then receives 0xA500. Valid mode codes include 0xA502 (segment), 0xA504 (main), 0xA506 (mass), 0xA50C (all main) and 0xA50E (global).
- R3: The fourth write goes to the captured address. It carries the captured data word for a program command and 0x55AA for an erase command.
- R4: After the target write, `tclk` goes low before a control-word request with `cw_word`=0x2409 is raised. `cw_req` is never high while `tclk` is high.
- R5: The pulse train has 35 pulses for a program command, whatever the value of `erase_pulses`. For an erase command it has `erase_pulses` pulses. A count of zero skips the train, and `tclk` then stays low until the release request is acknowledged.
- R6: Each pulse is `tclk` low for HALF_CLKS clocks followed by high for HALF_CLKS clocks. Rising edges of `tclk` occur only between the control-word acknowledge and the final lock write.
- R7: After the pulses, 0xA500 is written to 0x0128, then a release request is issued. `done` is high for exactly one cycle after the release acknowledge, and `busy` is low in the next cycle.
- R8: Each request stays high with stable `wr_addr`/`wr_data` until it is acknowledged. The block advances exactly one step per acknowledge, and at most one of the four request outputs is high at a time.
- R9: Command inputs are captured on the accepted start. Changes to them, and any `start` pulse while `busy` is high, have no effect on the running series and do not start a second one.
- R10: During and after reset, `busy`, `done` and all requests are low and `tclk` is high. `tclk` is high whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start a command; accepted only when idle |
| erase | input | 1 | 1 = erase, 0 = program one word |
| addr | input | AW | Target flash address |
| data | input | DW | Word to program |
| erase_mode | input | DW | Erase-mode code written to the first control register |
| erase_pulses | input | PW | Test-clock pulse count for an erase |
| busy | output | 1 | A series is in progress |
| done | output | 1 | One-cycle pulse at the end of the series |
| halt_req | output | 1 | Request to halt the target CPU |
| halt_ack | input | 1 | Halt completed |
| rel_req | output | 1 | Request to release the target CPU |
| rel_ack | input | 1 | Release completed |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | AW | Memory write address |
| wr_data | output | DW | Memory write data |
| wr_ack | input | 1 | Memory write completed |
| cw_req | output | 1 | Control-word shift request |
| cw_word | output | CW | Control word to shift |
| cw_ack | input | 1 | Control-word shift completed |
| tclk | output | 1 | Target test clock driven by the pulse generator |

## Verification
The bench targets erase counts of zero, one and several hundred. A design that ignored the zero case would pulse once or wrap to a huge count. One that counted off by one would miss the expected rising-edge total. It also gives program commands a stray `erase_pulses` value, which catches a design that reads that input in program mode. Acknowledges arrive at random delays and the command inputs are scrambled right after start. This exposes a design that re-samples its inputs or skips a step when back-to-back writes keep `wr_req` high. A second start injected mid-series catches a block that restarts or runs twice. The bench also times each low and high phase, and records `tclk` at the control-word shift and at the release. This shows pulse periods of the wrong width, a read-mode shift made with the clock high, and a clock restored too early after a skipped train.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int PW = 16,
  parameter int HALF_CLKS = 2,
  parameter int PROG_PULSES = 35,
  parameter logic [AW-1:0] CTL1_ADDR = 'h0128,
  parameter logic [AW-1:0] CTL2_ADDR = 'h012A,
  parameter logic [AW-1:0] CTL3_ADDR = 'h012C,
  parameter logic [DW-1:0] PROG_KEY  = 'hA540,
  parameter logic [DW-1:0] CTL2_VAL  = 'hA540,
  parameter logic [DW-1:0] CTL3_VAL  = 'hA500,
  parameter logic [DW-1:0] LOCK_VAL  = 'hA500,
  parameter logic [DW-1:0] DUMMY_VAL = 'h55AA,
  parameter logic [CW-1:0] READ_CW   = 'h2409
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          erase,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] erase_mode,
  input  logic [PW-1:0] erase_pulses,
  output logic          busy,
  output logic          done,
  output logic          halt_req,
  input  logic          halt_ack,
  output logic          rel_req,
  input  logic          rel_ack,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  output logic          cw_req,
  output logic [CW-1:0] cw_word,
  input  logic          cw_ack,
  output logic          tclk
);
  localparam int TW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_HALT, S_CTL1, S_CTL2, S_CTL3, S_TGT, S_TLOW,
    S_CW, S_PULSE, S_LOCK, S_REL, S_DONE
  } st_t;

  st_t           st;
  logic          erase_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, mode_q;
  logic [PW-1:0] pul_q, left;
  logic [TW-1:0] tim;
  logic          tclk_q;
  logic [PW-1:0] n_pulses;

  assign n_pulses = erase_q ? pul_q : PW'(PROG_PULSES);
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign halt_req = (st == S_HALT);
  assign rel_req  = (st == S_REL);
  assign cw_req   = (st == S_CW);
  assign cw_word  = READ_CW;
  assign wr_req   = (st == S_CTL1) || (st == S_CTL2) || (st == S_CTL3) ||
                    (st == S_TGT)  || (st == S_LOCK);
  assign tclk     = tclk_q;

  always_comb begin
    wr_addr = '0;
    wr_data = '0;
    case (st)
      S_CTL1: begin wr_addr = CTL1_ADDR; wr_data = erase_q ? mode_q : PROG_KEY; end
      S_CTL2: begin wr_addr = CTL2_ADDR; wr_data = CTL2_VAL; end
      S_CTL3: begin wr_addr = CTL3_ADDR; wr_data = CTL3_VAL; end
      S_TGT:  begin wr_addr = addr_q;    wr_data = erase_q ? DUMMY_VAL : data_q; end
      S_LOCK: begin wr_addr = CTL1_ADDR; wr_data = LOCK_VAL; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      mode_q  <= '0;
      pul_q   <= '0;
      left    <= '0;
      tim     <= '0;
      tclk_q  <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          erase_q <= erase;
          addr_q  <= addr;
          data_q  <= data;
          mode_q  <= erase_mode;
          pul_q   <= erase_pulses;
          st      <= S_HALT;
        end
        S_HALT: if (halt_ack) st <= S_CTL1;
        S_CTL1: if (wr_ack)   st <= S_CTL2;
        S_CTL2: if (wr_ack)   st <= S_CTL3;
        S_CTL3: if (wr_ack)   st <= S_TGT;
        S_TGT:  if (wr_ack)   st <= S_TLOW;
        S_TLOW: begin
          tclk_q <= 1'b0;
          st     <= S_CW;
        end
        S_CW: if (cw_ack) begin
          left <= n_pulses;
          tim  <= '0;
          st   <= (n_pulses == '0) ? S_LOCK : S_PULSE;
        end
        S_PULSE: begin
          if (tim == TW'(HALF_CLKS - 1)) begin
            tim <= '0;
            if (!tclk_q) begin
              tclk_q <= 1'b1;
            end else if (left == PW'(1)) begin
              left <= '0;
              st   <= S_LOCK;
            end else begin
              tclk_q <= 1'b0;
              left   <= left - PW'(1);
            end
          end else begin
            tim <= tim + TW'(1);
          end
        end
        S_LOCK: if (wr_ack) st <= S_REL;
        S_REL: if (rel_ack) begin
          tclk_q <= 1'b1;
          st     <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module flash_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] CTL1_ADDR = 'h0128,
  parameter logic [DW-1:0] LOCK_VAL  = 'hA500
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          halt_req,
  input logic          rel_req,
  input logic          wr_req,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          wr_ack,
  input logic          cw_req,
  input logic          tclk
);
  AST_HALT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> halt_req && !wr_req); // R1

  AST_CW_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cw_req |-> !tclk); // R4

  AST_REL_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rel_req) |-> $past(wr_req) && $past(wr_ack) &&
                       $past(wr_addr) == CTL1_ADDR && $past(wr_data) == LOCK_VAL); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R7

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data)); // R8

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_req, rel_req, wr_req, cw_req})); // R8

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tclk && !halt_req && !rel_req && !wr_req && !cw_req); // R10
endmodule

bind flash_seq flash_seq_chk #(
  .AW(AW), .DW(DW), .CTL1_ADDR(CTL1_ADDR), .LOCK_VAL(LOCK_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .halt_req(halt_req), .rel_req(rel_req), .wr_req(wr_req),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
  .cw_req(cw_req), .tclk(tclk)
);

// File: tb/flash_seq_tb.sv
module flash_seq_tb;
  localparam int HALF = 2;

  logic        clk = 0, rst_n = 0;
  logic        start = 0, erase = 0;
  logic [15:0] addr = 0, data = 0, erase_mode = 0, erase_pulses = 0;
  logic        busy, done, halt_req, rel_req, wr_req, cw_req, tclk;
  logic        halt_ack = 0, rel_ack = 0, wr_ack = 0, cw_ack = 0;
  logic [15:0] wr_addr, wr_data, cw_word;

  int n_chk = 0, n_bad = 0;

  flash_seq #(.HALF_CLKS(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .erase(erase), .addr(addr),
    .data(data), .erase_mode(erase_mode), .erase_pulses(erase_pulses),
    .busy(busy), .done(done), .halt_req(halt_req), .halt_ack(halt_ack),
    .rel_req(rel_req), .rel_ack(rel_ack), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .cw_req(cw_req), .cw_word(cw_word),
    .cw_ack(cw_ack), .tclk(tclk)
  );

  always #10 clk = ~clk;

  logic [2:0]  ev_t [0:15];
  logic [15:0] ev_a [0:15];
  logic [15:0] ev_d [0:15];
  logic        ev_k [0:15];
  int nev, rises, falls, werr, misp, ndone, run;
  logic prev_t;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Target stub and tclk monitor, one process so ordering is fixed
  initial begin
    nev = 0; rises = 0; falls = 0; werr = 0; misp = 0; ndone = 0; run = 0; prev_t = 1;
    forever begin
      @(negedge clk);
      if (tclk !== prev_t) begin
        if (tclk && nev < 8) begin
          rises++;
          if (nev != 6) misp++;
          if (falls >= 2 && run != HALF) werr++;
        end
        if (!tclk) begin
          falls++;
          if (rises >= 1 && run != HALF) werr++;
        end
        run = 1;
        prev_t = tclk;
      end else run++;
      if (done) ndone++;
      halt_ack = 0; rel_ack = 0; wr_ack = 0; cw_ack = 0;
      if ((halt_req || rel_req || wr_req || cw_req) && $urandom_range(0, 1) == 1) begin
        if (nev < 16) begin
          ev_t[nev] = halt_req ? 3'd1 : wr_req ? 3'd2 : cw_req ? 3'd3 : 3'd4;
          ev_a[nev] = wr_req ? wr_addr : 16'h0;
          ev_d[nev] = wr_req ? wr_data : cw_req ? cw_word : 16'h0;
          ev_k[nev] = tclk;
        end
        nev++;
        halt_ack = halt_req; rel_ack = rel_req; wr_ack = wr_req; cw_ack = cw_req;
      end
    end
  end

  function automatic logic [2:0] exp_t(input int i);
    case (i)
      0: return 3'd1;
      5: return 3'd3;
      7: return 3'd4;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [15:0] exp_a(input int i, input logic [15:0] a);
    case (i)
      1, 6: return 16'h0128;
      2: return 16'h012A;
      3: return 16'h012C;
      4: return a;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] exp_d(input int i, input logic er,
                                        input logic [15:0] d, input logic [15:0] m);
    case (i)
      1: return er ? m : 16'hA540;
      2: return 16'hA540;
      3, 6: return 16'hA500;
      4: return er ? 16'h55AA : d;
      5: return 16'h2409;
      default: return 16'h0;
    endcase
  endfunction

  function automatic string req_of(input int i);
    case (i)
      0: return "R1";
      1, 2, 3: return "R2";
      4: return "R3";
      5: return "R4";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [15:0] mode_code(input int k);
    case (k)
      0: return 16'hA502;
      1: return 16'hA504;
      2: return 16'hA506;
      3: return 16'hA50C;
      default: return 16'hA50E;
    endcase
  endfunction

  task automatic run_op(input logic er, input logic [15:0] a, input logic [15:0] d,
                        input logic [15:0] m, input logic [15:0] p, input bit inj);
    int cnt;
    int w;
    cnt = er ? int'(p) : 35;
    @(posedge clk); #2;
    nev = 0; rises = 0; falls = 0; werr = 0; misp = 0; ndone = 0; run = 0; prev_t = tclk;
    erase = er; addr = a; data = d; erase_mode = m; erase_pulses = p; start = 1;
    @(posedge clk); #2;
    start = 0;
    erase = 1'($urandom); addr = 16'($urandom); data = 16'($urandom);
    erase_mode = 16'($urandom); erase_pulses = 16'($urandom);
    if (inj) begin
      repeat (4) @(posedge clk);
      #2 start = 1;
      @(posedge clk); #2 start = 0;
    end
    w = 0;
    while (ndone == 0 && w < 5000) begin @(posedge clk); #2; w++; end
    repeat (6) @(posedge clk);
    #2;
    chk(nev == 8, "R8", "acknowledged steps", nev, 8);
    for (int i = 0; i < 8; i++) begin
      chk(ev_t[i] == exp_t(i) && ev_a[i] == exp_a(i, a) && ev_d[i] == exp_d(i, er, d, m),
          req_of(i), $sformatf("step %0d type/addr/data", i),
          {ev_t[i], ev_a[i], ev_d[i]}, {exp_t(i), exp_a(i, a), exp_d(i, er, d, m)});
    end
    chk(ev_k[5] == 1'b0, "R4", "tclk at control-word shift", ev_k[5], 0);
    chk(rises == cnt, "R5", "pulse count", rises, cnt);
    chk(ev_k[7] == (cnt != 0), "R5", "tclk at release", ev_k[7], cnt != 0);
    chk(werr == 0, "R6", "pulse phase width errors", werr, 0);
    chk(misp == 0, "R6", "pulses outside window", misp, 0);
    chk(ndone == 1, "R7", "done pulses", ndone, 1);
    chk(busy == 0 && tclk == 1, "R10", "idle busy/tclk", {busy, tclk}, 2'b01);
    if (inj) chk(ndone == 1 && nev == 8, "R9", "start while busy ignored", nev, 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    chk(!busy && !done && !halt_req && !rel_req && !wr_req && !cw_req && tclk,
        "R10", "outputs in reset", {busy, done, halt_req, rel_req, wr_req, cw_req, tclk}, 7'b0000001);
    rst_n = 1;
    repeat (2) @(posedge clk);
    #2;
    chk(!busy && tclk, "R10", "outputs after reset", {busy, tclk}, 2'b01);

    run_op(1'b0, 16'hF000, 16'h1234, 16'hA506, 16'd7, 1'b0);   // program ignores erase count
    run_op(1'b1, 16'hFFFE, 16'h0000, 16'hA506, 16'd0, 1'b0);   // zero count
    run_op(1'b1, 16'hE200, 16'h0000, 16'hA502, 16'd1, 1'b0);   // single pulse
    run_op(1'b1, 16'hFFFE, 16'h0000, 16'hA506, 16'd300, 1'b0); // long train
    run_op(1'b0, 16'hC000, 16'hBEEF, 16'h0000, 16'd0, 1'b1);   // start while busy
    for (int k = 0; k < 5; k++)
      run_op(1'b1, 16'($urandom), 16'($urandom), mode_code(k), 16'($urandom_range(0, 12)), 1'b0);
    for (int n = 0; n < 12; n++)
      run_op(1'($urandom), 16'($urandom), 16'($urandom), mode_code(int'($urandom_range(0, 4))),
             16'($urandom_range(0, 40)), 1'($urandom_range(0, 3) == 0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule